// File: doc/BRIEF.md
# ARINC 429 Transmit Channel

This block takes 32-bit ARINC 429 words from a host, queues up to eight of them, and sends them one at a time on a pair of return-to-zero lines. One line pulses for each one bit and the other line pulses for each zero bit. The host writes each word in two 16-bit halves. The first write holds the lower half. The second write completes the word and queues it.

While transmission is disabled, the host can read back any queued entry for a memory self-test. Reading back does not disturb the queue. When transmission is enabled, the serializer takes the oldest word and reorders its bits into wire order. It can replace the top bit with a parity bit. It times each bit from a programmable half-bit divisor, and it places a programmable null gap after each word. The channel flags an empty queue and a full queue. It can raise an interrupt once the last queued word has gone out.

Top module: `a429_tx_chan`

## Requirements
- R1: A pulse on `wr_lo_i` stores `wdata_i` as the pending lower half. Only the most recent lower-half write is kept. A pulse on `wr_hi_i` queues the word {`wdata_i`, pending lower half}.
- R2: The queue holds 8 words. `full_o` is high when it holds 8 words. A high-half write while the queue is full is dropped and leaves the queued contents unchanged.
- R3: `rd_data_o` shows the queued entry at position `rd_idx_i`, counted from the oldest (0). Reading does not remove the entry.
- R4: `empty_o` is high when no word is queued. Words are sent oldest first, and only while `tx_en_i` is high.
- R5: The half-bit time is D clock cycles, where D = `rate_div_i`, or 1 when `rate_div_i` is 0. A one bit drives `line_hi_o` high for D cycles. A zero bit drives `line_lo_o` high for D cycles. Both lines are then low for D cycles. The two lines are never high together.
- R6: Wire order sends word bit 7 down to bit 0 first, then bits 8 up to 31. Bit 0 is the LSB of the lower half.
- R7: `par_mode_i` selects the parity mode. 2'b01 sets bit 31 so that the word has an odd number of ones. 2'b10 sets bit 31 so that the word has an even number of ones. 2'b00 and 2'b11 send bit 31 as the host wrote it.
- R8: Let G = `gap_bits_i`, or 4 when `gap_bits_i` is below 4. When the next word is already queued, both lines stay low for exactly (2·G+1)·D+1 cycles between the last pulse of one word and the first pulse of the next.
- R9: The channel sets an internal done flag when a word completes with the queue empty. `irq_o` is that flag gated by `irq_en_i`. A high-half write or a pulse on `irq_clr_i` clears the flag. `irq_o` is never high while the queue holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Store lower half |
| wr_hi_i | input | 1 | Store upper half and queue word |
| wdata_i | input | 16 | Host write data |
| rd_idx_i | input | 3 | Readback position from oldest |
| rd_data_o | output | 32 | Readback word |
| tx_en_i | input | 1 | Transmit enable |
| rate_div_i | input | 8 | Half-bit time in clocks |
| par_mode_i | input | 2 | Parity mode |
| gap_bits_i | input | 4 | Null gap in bit times |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clear drained flag |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| irq_o | output | 1 | Drained interrupt |
| line_hi_o | output | 1 | RZ line for one bits |
| line_lo_o | output | 1 | RZ line for zero bits |

## Verification
Each way the internal state can go wrong shows up at the ports, and the timing of each is known.
- A corrupted queue pointer or count shows up first in `rd_data_o` or in the flags, one cycle after the write.
- A corrupted word shows up as a wrong decoded word or parity bit once its 32 pulses have gone out. That takes about 64·D cycles.
- A wrong bit counter or gap counter changes the measured pulse width or null length on the very next word boundary.
- A bad drained flag shows on `irq_o` as soon as the last word finishes.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LABEL_W = 8;
  localparam int unsigned MIN_GAP = 4;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_SEND = 2'b01,
    S_GAP  = 2'b10
  } ser_state_e;
endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  input  logic [AW-1:0] peek_idx_i,
  output logic [DW-1:0] peek_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;
  logic [AW-1:0] peek_addr;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign do_push   = push_i && !full_o;
  assign do_pop    = pop_i && !empty_o;
  assign head_o    = mem_q[rp_q];
  assign peek_addr = rp_q + peek_idx_i;
  assign peek_o    = mem_q[peek_addr];
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= push_data_i;
  end
endmodule

// File: rtl/a429_tx_frame.sv
module a429_tx_frame
  import a429_tx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        par_mode_i,
  output logic [WORD_W-1:0] seq_o
);
  logic [WORD_W-1:0] w;

  always_comb begin
    w = word_i;
    case (par_mode_e'(par_mode_i))
      PAR_ODD:  w[WORD_W-1] = ~^word_i[WORD_W-2:0];
      PAR_EVEN: w[WORD_W-1] =  ^word_i[WORD_W-2:0];
      default:  ;
    endcase
  end

  // wire order: label MSB first, then data LSB first
  for (genvar k = 0; k < WORD_W; k++) begin : g_ord
    if (k < LABEL_W) begin : g_lbl
      assign seq_o[k] = w[LABEL_W-1-k];
    end else begin : g_dat
      assign seq_o[k] = w[k];
    end
  end
endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned GAP_W = 4,
  localparam int unsigned GL_W = DIV_W + GAP_W + 1,
  localparam int unsigned BW   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              avail_i,
  input  logic [WORD_W-1:0] seq_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [GAP_W-1:0]  gap_i,
  output logic              pop_o,
  output logic              done_o,
  output logic [1:0]        state_o,
  output logic              line_hi_o,
  output logic              line_lo_o
);
  ser_state_e        st_q;
  logic [WORD_W-1:0] seq_q;
  logic [BW-1:0]     bit_q;
  logic              half_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [GL_W-1:0]   gcnt_q;
  logic [DIV_W-1:0]  div_eff;
  logic [GAP_W-1:0]  gap_eff;
  logic [GL_W-1:0]   gap_len;
  logic              half_end, cur;

  assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign gap_eff  = (gap_i < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : gap_i;
  assign gap_len  = (GL_W'(gap_eff) * GL_W'(div_eff)) << 1;
  assign half_end = (cnt_q == div_eff - 1'b1);
  assign pop_o    = (st_q == S_IDLE) && en_i && avail_i;
  assign done_o   = (st_q == S_SEND) && half_end && half_q && (bit_q == BW'(WORD_W-1));
  assign state_o  = st_q;
  assign cur      = seq_q[bit_q];
  assign line_hi_o = (st_q == S_SEND) && !half_q && cur;
  assign line_lo_o = (st_q == S_SEND) && !half_q && !cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      seq_q  <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
      cnt_q  <= '0;
      gcnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (pop_o) begin
          seq_q  <= seq_i;
          bit_q  <= '0;
          half_q <= 1'b0;
          cnt_q  <= '0;
          st_q   <= S_SEND;
        end
        S_SEND: begin
          if (half_end) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
            if (half_q) begin
              if (bit_q == BW'(WORD_W-1)) begin
                st_q   <= S_GAP;
                gcnt_q <= '0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_GAP: begin
          if (gcnt_q == gap_len - 1'b1) st_q <= S_IDLE;
          else                          gcnt_q <= gcnt_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_chan.sv
module a429_tx_chan
  import a429_tx_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned GAP_W  = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic [AW-1:0]       rd_idx_i,
  output logic [2*HALF_W-1:0] rd_data_o,
  input  logic                tx_en_i,
  input  logic [DIV_W-1:0]    rate_div_i,
  input  logic [1:0]          par_mode_i,
  input  logic [GAP_W-1:0]    gap_bits_i,
  input  logic                irq_en_i,
  input  logic                irq_clr_i,
  output logic                empty_o,
  output logic                full_o,
  output logic                irq_o,
  output logic                line_hi_o,
  output logic                line_lo_o
);
  logic [HALF_W-1:0]   lo_q;
  logic [2*HALF_W-1:0] head_word, seq_word;
  logic [CW-1:0]       fifo_cnt;
  logic                fifo_pop, word_done, done_q;
  logic [1:0]          ser_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lo_q <= '0;
    else if (wr_lo_i) lo_q <= wdata_i;
  end

  a429_tx_fifo #(.DEPTH(DEPTH), .DW(2*HALF_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i     (wr_hi_i),
    .push_data_i({wdata_i, lo_q}),
    .pop_i      (fifo_pop),
    .head_o     (head_word),
    .peek_idx_i (rd_idx_i),
    .peek_o     (rd_data_o),
    .cnt_o      (fifo_cnt),
    .empty_o    (empty_o),
    .full_o     (full_o)
  );

  a429_tx_frame u_frame (
    .word_i    (head_word),
    .par_mode_i(par_mode_i),
    .seq_o     (seq_word)
  );

  a429_tx_ser #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_ser (
    .clk_i, .rst_ni,
    .en_i     (tx_en_i),
    .avail_i  (!empty_o),
    .seq_i    (seq_word),
    .div_i    (rate_div_i),
    .gap_i    (gap_bits_i),
    .pop_o    (fifo_pop),
    .done_o   (word_done),
    .state_o  (ser_st),
    .line_hi_o(line_hi_o),
    .line_lo_o(line_lo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      done_q <= 1'b0;
    else if (wr_hi_i || irq_clr_i)    done_q <= 1'b0;
    else if (word_done && empty_o)    done_q <= 1'b1;
  end

  assign irq_o = done_q && irq_en_i;
endmodule

// File: rtl/a429_tx_chan_chk.sv
module a429_tx_chan_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          line_hi_o,
  input logic          line_lo_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          irq_o,
  input logic          wr_hi_i,
  input logic          fifo_pop,
  input logic [CW-1:0] fifo_cnt,
  input logic [1:0]    ser_st
);
  // R5
  one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_hi_o && line_lo_o));

  // R2
  full_not_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o);

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CW'(DEPTH) && wr_hi_i && !fifo_pop) |=> (fifo_cnt == CW'(DEPTH)));

  // R9
  irq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> empty_o);

  // R8
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_st == 2'b10) |-> (!line_hi_o && !line_lo_o));

  // R4
  pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop |-> !empty_o);
endmodule

bind a429_tx_chan a429_tx_chan_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .line_hi_o(line_hi_o),
  .line_lo_o(line_lo_o),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .irq_o    (irq_o),
  .wr_hi_i  (wr_hi_i),
  .fifo_pop (fifo_pop),
  .fifo_cnt (fifo_cnt),
  .ser_st   (ser_st)
);

// File: tb/a429_tx_chan_bench.sv
module a429_tx_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [15:0] wdata = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        tx_en = 1'b0;
  logic [7:0]  rate_div = 8'd2;
  logic [1:0]  par_mode = 2'b00;
  logic [3:0]  gap_bits = 4'd4;
  logic        irq_en = 1'b1, irq_clr = 1'b0;
  logic        empty, full, irq, lhi, llo;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  a429_tx_chan u_a429_tx_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .tx_en_i(tx_en), .rate_div_i(rate_div), .par_mode_i(par_mode),
    .gap_bits_i(gap_bits), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .empty_o(empty), .full_o(full), .irq_o(irq),
    .line_hi_o(lhi), .line_lo_o(llo)
  );

  // line monitor: decodes words and measures pulse width and null runs
  logic [31:0] rx_words [64];
  int rx_n = 0, bitk = 0, lowrun = 0, gap_last = 0, hw = 0, width_last = 0;
  int both_hi = 0;
  logic prev_hi = 1'b0, prev_lo = 1'b0;
  logic [31:0] seq_acc = '0;

  always @(negedge clk) begin
    if (lhi && llo) both_hi++;
    if ((lhi && !prev_hi) || (llo && !prev_lo)) begin
      if (bitk == 0 && rx_n > 0) gap_last = lowrun;
      seq_acc[bitk] = lhi;
      bitk++;
      if (bitk == 32) begin
        logic [31:0] w;
        for (int k = 0; k < 32; k++) begin
          if (k < 8) w[7-k] = seq_acc[k];
          else       w[k]   = seq_acc[k];
        end
        if (rx_n < 64) rx_words[rx_n] = w;
        rx_n++;
        bitk = 0;
      end
    end
    if (!lhi && !llo) lowrun++;
    else lowrun = 0;
    if (lhi || llo) hw++;
    else if (hw != 0) begin
      width_last = hw;
      hw = 0;
    end
    prev_hi = lhi;
    prev_lo = llo;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] w);
    @(negedge clk); wr_lo = 1'b1; wdata = w[15:0];
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = w[31:16];
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic wait_words(input int target);
    for (int i = 0; i < 60000 && rx_n < target; i++) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(empty == 1'b1, "R4 reset empty", empty, 1);
    check(full == 1'b0, "R2 reset full", full, 0);
    check(irq == 1'b0, "R9 reset irq", irq, 0);
    check(!lhi && !llo, "R5 reset lines", {lhi, llo}, 0);
  endtask

  task automatic t_fill_drain();
    logic [31:0] exp_w [9];
    int base;
    tx_en = 1'b0; par_mode = 2'b00; rate_div = 8'd2; gap_bits = 4'd4;
    for (int i = 0; i < 9; i++) exp_w[i] = 32'h1357_0000 + 32'h0102_0305 * i;
    for (int i = 0; i < 9; i++) wr_word(exp_w[i]);
    check(full == 1'b1, "R2 full after nine writes", full, 1);
    rd_idx = 3'd0; #1;
    check(rd_data == exp_w[0], "R3 readback oldest", rd_data, exp_w[0]);
    rd_idx = 3'd7; #1;
    check(rd_data == exp_w[7], "R2 entry 7 kept, 9th dropped", rd_data, exp_w[7]);
    rd_idx = 3'd0; #1;
    check(rd_data == exp_w[0], "R3 readback non-destructive", rd_data, exp_w[0]);
    check(rx_n == 0, "R4 nothing sent while disabled", rx_n, 0);
    base = rx_n;
    @(negedge clk); tx_en = 1'b1;
    wait_words(base + 8);
    for (int i = 0; i < 8; i++)
      check(rx_words[base+i] == exp_w[i], "R6 word order and bit order", rx_words[base+i], exp_w[i]);
    check(width_last == 2, "R5 pulse width D=2", width_last, 2);
    check(gap_last == 19, "R8 null run D=2 G=4", gap_last, 19);
    repeat (300) @(negedge clk);
    check(rx_n == base + 8, "R2 dropped word never sent", rx_n, base + 8);
    check(empty == 1'b1, "R4 empty after drain", empty, 1);
    check(irq == 1'b1, "R9 irq after drain", irq, 1);
    irq_en = 1'b0; #1;
    check(irq == 1'b0, "R9 irq masked", irq, 0);
    irq_en = 1'b1;
    pulse_clr();
    check(irq == 1'b0, "R9 irq cleared", irq, 0);
  endtask

  task automatic t_halves();
    int base;
    tx_en = 1'b0;
    @(negedge clk); wr_lo = 1'b1; wdata = 16'hAAAA;
    @(negedge clk); wdata = 16'h5B5B;
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wdata = 16'hC3C3;
    @(negedge clk); wr_hi = 1'b0;
    rd_idx = 3'd0; #1;
    check(rd_data == 32'hC3C3_5B5B, "R1 last lower half kept", rd_data, 32'hC3C3_5B5B);
    base = rx_n;
    tx_en = 1'b1;
    wait_words(base + 1);
    check(rx_words[base] == 32'hC3C3_5B5B, "R1 assembled word sent", rx_words[base], 32'hC3C3_5B5B);
    repeat (40) @(negedge clk);
    pulse_clr();
  endtask

  task automatic t_parity(input logic [1:0] mode, input logic [31:0] w, input logic [31:0] e, input string tag);
    int base;
    tx_en = 1'b0; par_mode = mode;
    wr_word(w);
    base = rx_n;
    tx_en = 1'b1;
    wait_words(base + 1);
    check(rx_words[base] == e, tag, rx_words[base], e);
    repeat (40) @(negedge clk);
  endtask

  task automatic t_timing(input logic [7:0] d, input logic [3:0] g, input int ew, input int eg, input string tag);
    int base;
    tx_en = 1'b0; par_mode = 2'b00; rate_div = d; gap_bits = g;
    wr_word(32'h0000_0080);
    wr_word(32'h7FFF_FF01);
    base = rx_n;
    tx_en = 1'b1;
    wait_words(base + 2);
    check(rx_words[base] == 32'h0000_0080, {tag, " R6 label msb first"}, rx_words[base], 32'h0000_0080);
    check(width_last == ew, {tag, " R5 width"}, width_last, ew);
    check(gap_last == eg, {tag, " R8 null run"}, gap_last, eg);
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_drain();
    t_halves();
    // R7: odd / even / none
    t_parity(2'b01, 32'h8000_0001, 32'h0000_0001, "R7 odd clears bit31");
    t_parity(2'b01, 32'h0000_0003, 32'h8000_0003, "R7 odd sets bit31");
    t_parity(2'b10, 32'h0000_0001, 32'h8000_0001, "R7 even sets bit31");
    t_parity(2'b10, 32'h8000_0003, 32'h0000_0003, "R7 even clears bit31");
    t_parity(2'b00, 32'h8000_0003, 32'h8000_0003, "R7 none keeps bit31");
    t_parity(2'b11, 32'h0000_0001, 32'h0000_0001, "R7 mode 3 keeps bit31");
    t_timing(8'd3, 4'd2, 3, 28, "D=3 G<4");
    t_timing(8'd0, 4'd6, 1, 14, "D=0 G=6");
    check(both_hi == 0, "R5 lines never both high", both_hi, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule